// File: doc/BRIEF.md
# Keyboard Controller Register Interface

This block sits between a processor's byte-wide register bus and a simplified keyboard-side link. Software sees two port offsets. The control offset (0x64) reads as an 8-bit status byte and accepts command bytes when written. The data offset (0x60) returns the buffered scancode when read and accepts outgoing bytes when written. The intended software pattern is polling: wait until the output-full flag reads 1, then fetch the byte from the data offset.

The keyboard side presents received scancode bytes with a one-cycle valid strobe. The block holds a single scancode for the host. Outgoing bytes leave on a one-cycle send strobe with the byte alongside.

Three command values are decoded:
- 0xAA runs a self test, which places 0x55 in the buffer one cycle later.
- 0xAE enables reception from the keyboard.
- 0xED marks the next data-offset write as a new LED state.

Top module: `kbc_regif`

## Requirements
- R1: After a synchronous reset the status byte reads 0x00, `led_state` is 0x00, `kb_tx_send` is 0, and reception is disabled.
- R2: The status byte reads at offset 0x64 with bit 0 = output full, bit 1 = input busy, bit 2 = self-test done, and bits 7..3 always 0; the buffer reads at offset 0x60; any other offset, or a cycle without `host_rd`, reads 0x00.
- R3: While reception is enabled and output full is 0, a `kb_rx_valid` cycle stores `kb_rx_byte` in the buffer and sets output full at that clock edge.
- R4: While reception is disabled, `kb_rx_valid` leaves the buffer and output full unchanged.
- R5: A scancode that arrives while output full is 1 is dropped: the buffered byte is kept and status bit 6 stays 0.
- R6: A read at offset 0x60 returns the buffered byte and clears output full at that clock edge.
- R7: A write of 0xAA at offset 0x64 leaves output full untouched at its own edge. At the following edge it loads 0x55 into the buffer and sets output full and self-test done, overriding any other buffer update in that cycle.
- R8: A write of 0xAE at offset 0x64 enables reception.
- R9: After a write of 0xED at offset 0x64, the next write at offset 0x60 loads `led_state`. Later data writes leave `led_state` unchanged.
- R10: Every write at offset 0x60 raises `kb_tx_send` for exactly the following cycle, with `kb_tx_byte` equal to the written byte.
- R11: Input busy reads 1 for exactly the cycle after a host write at offset 0x60 or 0x64. A write at any other offset does not set it.
- R12: A command byte other than 0xAA, 0xAE and 0xED changes nothing except input busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Register bus port offset |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational) |
| kb_rx_valid | input | 1 | Received scancode strobe |
| kb_rx_byte | input | 8 | Received scancode |
| kb_tx_send | output | 1 | Outgoing byte strobe |
| kb_tx_byte | output | 8 | Outgoing byte |
| led_state | output | 8 | Current LED state register |

## Verification
The bench checks the following corner cases, each against the specific failure it would expose:
- **Scancode while the buffer is full.** A design that overwrites instead of dropping would return the second byte on the next read.
- **Scancodes before and after the enable command, and after an unknown command.** A wrong enable decode would fill the buffer while reception is still disabled.
- **Two-edge timing of the self test.** It samples status right after the command edge, where output full must still be 0, and again one edge later. A design that completes early, or forgets the self-test flag, shows the wrong status byte in one of those two cycles.
- **Set-LEDs arming.** It is checked to apply to one data write only. A design that left it armed would change `led_state` on the second write.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_SELFTEST = 8'hAA;
    localparam logic [BYTE_W-1:0] CMD_KB_ON    = 8'hAE;
    localparam logic [BYTE_W-1:0] CMD_LED_ARM  = 8'hED;

    // Status byte, MSB first; bit 0 must stay the output-full flag.
    typedef struct packed {
        logic parity_err;
        logic rx_timeout;
        logic aux_data;
        logic kb_locked;
        logic cmd_last;
        logic self_ok;
        logic in_busy;
        logic out_full;
    } kbc_status_t;

    typedef struct packed {
        logic selftest;
        logic kb_on;
        logic led_arm;
    } kbc_cmd_t;

    function automatic kbc_cmd_t decode_cmd(input logic strobe, input logic [BYTE_W-1:0] b);
        kbc_cmd_t c;
        c.selftest = strobe && (b == CMD_SELFTEST);
        c.kb_on    = strobe && (b == CMD_KB_ON);
        c.led_arm  = strobe && (b == CMD_LED_ARM);
        return c;
    endfunction

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  logic              cmd_wr,
    input  logic [BYTE_W-1:0] cmd_byte,
    output kbc_cmd_t          cmd
);
    always_comb cmd = decode_cmd(cmd_wr, cmd_byte);
endmodule

// File: rtl/kbc_outbuf.sv
module kbc_outbuf #(
    parameter int              DW      = 8,
    parameter logic [DW-1:0]   TEST_OK = 'h55
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_take,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          test_load,
    output logic          full_q,
    output logic [DW-1:0] byte_q
);
    logic accept;
    assign accept = rx_valid && !full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            byte_q <= '0;
        end else if (test_load) begin
            full_q <= 1'b1;
            byte_q <= TEST_OK;
        end else if (accept) begin
            full_q <= 1'b1;
            byte_q <= rx_byte;
        end else if (host_take) begin
            full_q <= 1'b0;
        end
    end
endmodule

// File: rtl/kbc_ledport.sv
module kbc_ledport #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] led_q,
    output logic          send_q,
    output logic [DW-1:0] send_byte_q
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q     <= 1'b0;
            led_q       <= '0;
            send_q      <= 1'b0;
            send_byte_q <= '0;
        end else begin
            send_q <= data_wr;
            if (data_wr) begin
                send_byte_q <= wdata;
            end
            if (data_wr && armed_q) begin
                led_q   <= wdata;
                armed_q <= 1'b0;
            end else if (arm) begin
                armed_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/kbc_regif.sv
module kbc_regif
    import kbc_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 'h60,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h64,
    parameter logic [BYTE_W-1:0] TEST_OK   = 'h55
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              kb_rx_valid,
    input  logic [7:0]        kb_rx_byte,
    output logic              kb_tx_send,
    output logic [7:0]        kb_tx_byte,
    output logic [7:0]        led_state
);
    logic hit_data, hit_ctrl, wr_data, wr_ctrl, rd_data;
    assign hit_data = (host_addr == DATA_ADDR);
    assign hit_ctrl = (host_addr == CTRL_ADDR);
    assign wr_data  = host_wr && hit_data;
    assign wr_ctrl  = host_wr && hit_ctrl;
    assign rd_data  = host_rd && hit_data;

    kbc_cmd_t cmd;
    kbc_cmd_decode u_dec (
        .cmd_wr   (wr_ctrl),
        .cmd_byte (host_wdata),
        .cmd      (cmd)
    );

    logic kb_en_q, test_pend_q, self_ok_q, in_busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kb_en_q     <= 1'b0;
            test_pend_q <= 1'b0;
            self_ok_q   <= 1'b0;
            in_busy_q   <= 1'b0;
        end else begin
            in_busy_q   <= wr_data || wr_ctrl;
            test_pend_q <= cmd.selftest;
            if (cmd.kb_on)   kb_en_q   <= 1'b1;
            if (test_pend_q) self_ok_q <= 1'b1;
        end
    end

    logic            out_full;
    logic [BYTE_W-1:0] out_byte;

    kbc_outbuf #(.DW(BYTE_W), .TEST_OK(TEST_OK)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .host_take (rd_data),
        .rx_valid  (kb_rx_valid && kb_en_q),
        .rx_byte   (kb_rx_byte),
        .test_load (test_pend_q),
        .full_q    (out_full),
        .byte_q    (out_byte)
    );

    kbc_ledport #(.DW(BYTE_W)) u_led (
        .clk         (clk),
        .rst         (rst),
        .arm         (cmd.led_arm),
        .data_wr     (wr_data),
        .wdata       (host_wdata),
        .led_q       (led_state),
        .send_q      (kb_tx_send),
        .send_byte_q (kb_tx_byte)
    );

    kbc_status_t status_q;
    always_comb begin
        status_q          = '0;
        status_q.out_full = out_full;
        status_q.in_busy  = in_busy_q;
        status_q.self_ok  = self_ok_q;
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd && hit_ctrl)      host_rdata = status_q;
        else if (host_rd && hit_data) host_rdata = out_byte;
    end
endmodule

// File: rtl/kbc_regif_chk.sv
module kbc_regif_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 'h60,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h64
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rd,
    input logic              host_wr,
    input logic [7:0]        host_wdata,
    input logic              kb_rx_valid,
    input logic              kb_tx_send,
    input logic [7:0]        kb_tx_byte,
    input logic [7:0]        led_state,
    input logic [7:0]        status_q
);
    logic test_wr, data_wr, port_wr, data_rd;
    assign test_wr = host_wr && (host_addr == CTRL_ADDR) && (host_wdata == 8'hAA);
    assign data_wr = host_wr && (host_addr == DATA_ADDR);
    assign port_wr = data_wr || (host_wr && (host_addr == CTRL_ADDR));
    assign data_rd = host_rd && (host_addr == DATA_ADDR);

    assert_fixed_zero_R2: assert property (@(posedge clk) disable iff (rst)
        status_q[7:3] == 5'd0);

    assert_full_source_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[0]) |-> ($past(kb_rx_valid) || $past(test_wr, 2)));

    assert_read_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (data_rd && status_q[0] && !$past(test_wr)) |=> !status_q[0]);

    assert_led_source_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(led_state) |-> $past(data_wr));

    assert_send_source_R10: assert property (@(posedge clk) disable iff (rst)
        kb_tx_send |-> ($past(data_wr) && kb_tx_byte == $past(host_wdata)));

    assert_busy_set_R11: assert property (@(posedge clk) disable iff (rst)
        port_wr |=> status_q[1]);

    assert_busy_clear_R11: assert property (@(posedge clk) disable iff (rst)
        !port_wr |=> !status_q[1]);
endmodule

bind kbc_regif kbc_regif_chk #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_addr   (host_addr),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .kb_rx_valid (kb_rx_valid),
    .kb_tx_send  (kb_tx_send),
    .kb_tx_byte  (kb_tx_byte),
    .led_state   (led_state),
    .status_q    (status_q)
);

// File: tb/kbc_regif_test.sv
module kbc_regif_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_addr = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       kb_rx_valid = 1'b0;
    logic [7:0] kb_rx_byte = '0;
    logic       kb_tx_send;
    logic [7:0] kb_tx_byte, led_state;

    always #4 clk = ~clk;

    kbc_regif uut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .kb_rx_valid(kb_rx_valid), .kb_rx_byte(kb_rx_byte),
        .kb_tx_send(kb_tx_send), .kb_tx_byte(kb_tx_byte), .led_state(led_state)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    bit m_full, m_en, m_selfok, m_busy, m_arm, m_pend, m_send;
    int m_buf, m_led, m_txb;

    always @(posedge clk) begin
        bit rdd, wrc, wrd;
        rdd = host_rd && host_addr == 8'h60;
        wrc = host_wr && host_addr == 8'h64;
        wrd = host_wr && host_addr == 8'h60;
        if (rst) begin
            m_full = 0; m_en = 0; m_selfok = 0; m_busy = 0; m_arm = 0;
            m_pend = 0; m_send = 0; m_buf = 0; m_led = 0; m_txb = 0;
        end else begin
            if (m_pend) begin
                m_buf = 8'h55; m_full = 1; m_selfok = 1;
            end else if (m_en && kb_rx_valid && !m_full) begin
                m_buf = kb_rx_byte; m_full = 1;
            end else if (rdd) begin
                m_full = 0;
            end
            m_pend = wrc && host_wdata == 8'hAA;
            if (wrc && host_wdata == 8'hAE) m_en = 1;
            m_busy = wrc || wrd;
            m_send = wrd;
            if (wrd) m_txb = host_wdata;
            if (wrd && m_arm) begin
                m_led = host_wdata; m_arm = 0;
            end else if (wrc && host_wdata == 8'hED) m_arm = 1;
        end
        #2;
        if (!rst && !done) begin
            int exp_rd;
            exp_rd = 0;
            if (host_rd && host_addr == 8'h64) exp_rd = {5'd0, m_selfok, m_busy, m_full};
            else if (host_rd && host_addr == 8'h60) exp_rd = m_buf;
            check("R2 model rdata", host_rdata, exp_rd);
            check("R9 model led", led_state, m_led);
            check("R10 model send", kb_tx_send, m_send);
            check("R10 model byte", kb_tx_byte, m_txb);
        end
    end

    // Drive one cycle starting at a falling edge; optionally check read data.
    task automatic step(input bit rd, input bit wr, input logic [7:0] a,
                        input logic [7:0] d, input bit rv, input logic [7:0] rb,
                        input bit chk, input logic [7:0] exp, input string tag);
        host_rd = rd; host_wr = wr; host_addr = a; host_wdata = d;
        kb_rx_valid = rv; kb_rx_byte = rb;
        #1;
        if (chk) check(tag, host_rdata, exp);
        @(negedge clk);
        host_rd = 0; host_wr = 0; kb_rx_valid = 0;
    endtask

    task automatic idle();
        step(0, 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, "");
    endtask

    initial begin
        int wd = 0;
        while (!done) begin
            @(posedge clk);
            wd++;
            if (wd > 20000) begin
                fails++; checks++;
                $display("FAIL watchdog expired actual %0d expected <20000", wd);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1 led", led_state, 0);
        check("R1 send", kb_tx_send, 0);
        step(1, 0, 8'h64, 0, 0, 0, 1, 8'h00, "R1 status");
        // R4: reception disabled after reset
        step(0, 0, 8'h00, 0, 1, 8'h1C, 0, 0, "");
        step(1, 0, 8'h64, 0, 0, 0, 1, 8'h00, "R4 full stays 0");
        // R12: unknown command; R11 busy pulse
        step(0, 1, 8'h64, 8'h12, 0, 0, 0, 0, "");
        step(1, 0, 8'h64, 0, 0, 0, 1, 8'h02, "R11 busy after command write");
        step(1, 0, 8'h64, 0, 1, 8'h1C, 1, 8'h00, "R11 busy single cycle");
        step(1, 0, 8'h64, 0, 0, 0, 1, 8'h00, "R12 unknown command left reception off");
        // R8 enable, R3 accept
        step(0, 1, 8'h64, 8'hAE, 0, 0, 0, 0, "");
        step(0, 0, 8'h00, 0, 1, 8'h1C, 0, 0, "");
        step(1, 0, 8'h64, 0, 0, 0, 1, 8'h01, "R3 full set after enable (R8)");
        // R5 drop while full
        step(0, 0, 8'h00, 0, 1, 8'h32, 0, 0, "");
        step(1, 0, 8'h64, 0, 0, 0, 1, 8'h01, "R5 no timeout flag");
        // R6 read clears
        step(1, 0, 8'h60, 0, 0, 0, 1, 8'h1C, "R5 R6 kept byte returned");
        step(1, 0, 8'h64, 0, 0, 0, 1, 8'h00, "R6 full cleared");
        // R7 self test timing
        step(0, 1, 8'h64, 8'hAA, 0, 0, 0, 0, "");
        step(1, 0, 8'h64, 0, 0, 0, 1, 8'h02, "R7 not done at command edge");
        step(1, 0, 8'h64, 0, 0, 0, 1, 8'h05, "R7 done one edge later");
        step(1, 0, 8'h60, 0, 0, 0, 1, 8'h55, "R7 self-test byte");
        // R10 plain data write
        step(0, 1, 8'h60, 8'h77, 0, 0, 0, 0, "");
        check("R10 send pulse", kb_tx_send, 1);
        check("R10 send byte", kb_tx_byte, 8'h77);
        check("R10 led unchanged", led_state, 0);
        idle();
        check("R10 send one cycle", kb_tx_send, 0);
        // R9 set LEDs
        step(0, 1, 8'h64, 8'hED, 0, 0, 0, 0, "");
        step(0, 1, 8'h60, 8'h05, 0, 0, 0, 0, "");
        check("R9 led loaded", led_state, 8'h05);
        step(0, 1, 8'h60, 8'h09, 0, 0, 0, 0, "");
        check("R9 arm used once", led_state, 8'h05);
        check("R10 second byte", kb_tx_byte, 8'h09);
        // R2 other offset, R11 no busy on other offset
        step(1, 0, 8'h61, 0, 0, 0, 1, 8'h00, "R2 other offset reads zero");
        step(0, 1, 8'h50, 8'hAE, 0, 0, 0, 0, "");
        step(1, 0, 8'h64, 0, 0, 0, 1, 8'h04, "R11 no busy for other offset");
        step(0, 0, 8'h64, 0, 0, 0, 1, 8'h00, "R2 no read strobe reads zero");
        // R3 again with a different byte after clearing
        step(0, 0, 8'h00, 0, 1, 8'hE0, 0, 0, "");
        step(1, 0, 8'h60, 0, 0, 0, 1, 8'hE0, "R3 second scancode");
        idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule